// File: doc/BRIEF.md
# SPI Master Controller with Word FIFOs

This block is a register-programmed serial peripheral interface master. Software writes words into a 16-entry transmit queue through a small register bus. The controller shifts each word out on the serial data output, MSB first, and on the same clock edges captures the serial data input into a 16-entry receive queue. The word length, the clock polarity and phase, the serial clock rate and the chip-select line are all set through two configuration registers and a prescale register. Status and flush registers let software track and empty the queues.

Framing has two styles. In the per-word style, chip select is released after every word and stays high for at least one serial clock period before the next word starts. In the framed style, chip select stays low while queued words go out back to back. The frame closes after a word written with its end-of-frame tag set, or when the queue runs dry. A hold bit keeps the shifter idle, so software can load a whole frame into the queue before any bit leaves. An internal loopback feeds the serial output back into the receiver. A chip-select mute keeps every select line high while shifting still takes place.

Register map (3-bit address): 0 = format (`[3:0]` length minus one, `[4]` polarity, `[5]` phase, `[15:8]` rate divider). 1 = control (`[0]` run, `[1]` loopback, `[2]` select mute, `[3]` framed, `[4]` hold, `[7:5]` select index). 2 = data (a write queues `[15:0]` with the end-of-frame tag in `[31]`; a read pops the receive queue). 3 = status (`[0]` transmit not full, `[1]` receive not empty, `[2]` transmit empty). 4 = flush (`[0]` receive, `[1]` transmit; write only). 5 = prescale `[7:0]`.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, every chip-select line is high, `sck` is low and the status register reads 5 (transmit not full, transmit empty). Whenever no word is being shifted, `sck` rests at the polarity bit (format bit 4). The reset word length is 8 bits.
- R2: Format bits `[3:0]` hold the word length minus one, so 3 gives 4 bits and 15 gives 16 bits. A word uses the low bits of the data written and goes out MSB first, with two `sck` edges per bit. Received words are masked to that length.
- R3: Polarity (format bit 4) and phase (format bit 5) select the four SPI modes. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R4: One `sck` period lasts prescale × (divider + 1) bus clocks. The prescale comes from register 5 and the divider from format bits `[15:8]`. The product is taken as even and at least 2.
- R5: Every word shifted out pushes exactly one received word into the receive queue, in order.
- R6: With loopback (control bit 1) set, the receiver takes the block's own serial output and ignores `miso`.
- R7: Control bits `[7:5]` choose which one of the eight active-low `csN` lines is driven during a frame. With select mute (control bit 2) set, all lines stay high.
- R8: In framed mode (control bit 3), chip select stays low across consecutive queued words. It is released after a word tagged with data bit 31, or when the transmit queue is empty.
- R9: Outside framed mode, chip select goes high after each word and stays high for at least one `sck` period before the next word.
- R10: While hold (control bit 4) is set, no word starts, even with data queued. Clearing the bit releases the transmission.
- R11: While run (control bit 0) is clear, no word starts.
- R12: A data write while the transmit queue holds 16 words is dropped. Status bit 0 shows the queue is not full.
- R13: Reading data from an empty receive queue returns 0 and changes nothing. A received word that arrives while the receive queue is full is discarded.
- R14: Writing flush bit 1 empties the transmit queue, and writing flush bit 0 empties the receive queue, each independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops receive data at address 2) |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid in the same cycle as the address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 8 | Active-low chip selects |

## Verification
A corrupted shift or edge counter shows within one word. It appears as a wrong `sck` edge count between chip-select transitions, or as data on the serial pins or in the receive queue that is shifted by a bit. A wrong framing state shows at the next word boundary: chip select either fails to rise after a tagged word or rises inside a frame. A damaged queue pointer or count shows on the very next status read or data pop, as a wrong flag, a lost word or out-of-order data. A select line that should be quiet but falls, under hold, stopped run or mute, shows on `csN` in the cycle after the start decision.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int WORD_MAX = 16;
  localparam int SIZE_W   = $clog2(WORD_MAX);
  localparam int PRE_W    = 8;
  localparam int DIV_W    = 8;
  localparam int CS_W     = 3;
  localparam int NUM_CS   = 1 << CS_W;

  localparam logic [2:0] ADDR_FMT   = 3'd0;
  localparam logic [2:0] ADDR_CTRL  = 3'd1;
  localparam logic [2:0] ADDR_DATA  = 3'd2;
  localparam logic [2:0] ADDR_STAT  = 3'd3;
  localparam logic [2:0] ADDR_FLUSH = 3'd4;
  localparam logic [2:0] ADDR_PRE   = 3'd5;

  typedef struct packed {
    logic [SIZE_W-1:0] sizeM1;
    logic              cpol;
    logic              cpha;
    logic [DIV_W-1:0]  rateDiv;
    logic [PRE_W-1:0]  prescale;
    logic              enable;
    logic              loopback;
    logic              csOff;
    logic              blockMode;
    logic              txHold;
    logic [CS_W-1:0]   csSel;
  } spiCfg_t;

  typedef struct packed {
    logic load;        // pop transmit head into the shifter
    logic outEdge;     // present next bit on the serial output
    logic sampleEdge;  // capture one input bit
    logic rxPush;      // move the assembled word into the receive queue
  } spiStrobes_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W = 17,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic          regRe,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  input  logic          miso,
  input  spiStrobes_t   strobes,
  output spiCfg_t       cfg,
  output logic          txEmpty,
  output logic          txFull,
  output logic          curStop,
  output logic          mosi,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount
);
  localparam int TXW = WORD_MAX + 1;

  logic [TXW-1:0]      txHead;
  logic [WORD_MAX-1:0] rxHead, txShift, rxShift, aligned, lenMask;
  logic rxEmpty, rxFull, mosiBit, inBit;
  logic wrData, wrFlush, rdData;

  assign wrData  = regWe && (regAddr == ADDR_DATA);
  assign wrFlush = regWe && (regAddr == ADDR_FLUSH);
  assign rdData  = regRe && (regAddr == ADDR_DATA);

  spi_word_fifo #(.W(TXW), .DEPTH(DEPTH)) txQueue (
    .clk(clk), .rstN(rstN), .clr(wrFlush && regWdata[1]),
    .push(wrData), .pushData({regWdata[31], regWdata[WORD_MAX-1:0]}),
    .pop(strobes.load), .head(txHead), .count(txCount),
    .empty(txEmpty), .full(txFull));

  spi_word_fifo #(.W(WORD_MAX), .DEPTH(DEPTH)) rxQueue (
    .clk(clk), .rstN(rstN), .clr(wrFlush && regWdata[0]),
    .push(strobes.rxPush), .pushData(rxShift & lenMask),
    .pop(rdData), .head(rxHead), .count(rxCount),
    .empty(rxEmpty), .full(rxFull));

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
      cfg.sizeM1 <= SIZE_W'(7);
      cfg.prescale <= PRE_W'(2);
    end else if (regWe) begin
      case (regAddr)
        ADDR_FMT: begin
          cfg.sizeM1  <= regWdata[SIZE_W-1:0];
          cfg.cpol    <= regWdata[4];
          cfg.cpha    <= regWdata[5];
          cfg.rateDiv <= regWdata[8 +: DIV_W];
        end
        ADDR_CTRL: begin
          cfg.enable    <= regWdata[0];
          cfg.loopback  <= regWdata[1];
          cfg.csOff     <= regWdata[2];
          cfg.blockMode <= regWdata[3];
          cfg.txHold    <= regWdata[4];
          cfg.csSel     <= regWdata[5 +: CS_W];
        end
        ADDR_PRE: cfg.prescale <= regWdata[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_FMT:  regRdata = 32'({cfg.rateDiv, 2'b00, cfg.cpha, cfg.cpol, cfg.sizeM1});
      ADDR_CTRL: regRdata = 32'({cfg.csSel, cfg.txHold, cfg.blockMode, cfg.csOff,
                                 cfg.loopback, cfg.enable});
      ADDR_DATA: regRdata = rxEmpty ? '0 : 32'(rxHead);
      ADDR_STAT: regRdata = 32'({txEmpty, !rxEmpty, !txFull});
      ADDR_PRE:  regRdata = 32'(cfg.prescale);
      default:   regRdata = '0;
    endcase
  end

  // shifter
  assign aligned = txHead[WORD_MAX-1:0] << (SIZE_W'(WORD_MAX - 1) - cfg.sizeM1);
  assign lenMask = {WORD_MAX{1'b1}} >> (SIZE_W'(WORD_MAX - 1) - cfg.sizeM1);
  assign inBit   = cfg.loopback ? mosiBit : miso;
  assign mosi    = mosiBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      mosiBit <= 1'b0;
      curStop <= 1'b0;
    end else begin
      if (strobes.load) begin
        rxShift <= '0;
        curStop <= txHead[TXW-1];
        if (cfg.cpha) begin
          txShift <= aligned;
          mosiBit <= 1'b0;
        end else begin
          txShift <= aligned << 1;
          mosiBit <= aligned[WORD_MAX-1];
        end
      end else begin
        if (strobes.outEdge) begin
          mosiBit <= txShift[WORD_MAX-1];
          txShift <= txShift << 1;
        end
        if (strobes.sampleEdge) rxShift <= {rxShift[WORD_MAX-2:0], inBit};
      end
    end
  end
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spiCfg_t           cfg,
  input  logic              txEmpty,
  input  logic              curStop,
  output spiStrobes_t       strobes,
  output logic              sck,
  output logic [NUM_CS-1:0] csN,
  output logic              frameActive
);
  localparam int LEN_W  = SIZE_W + 1;
  localparam int EDGE_W = LEN_W + 1;
  localparam int PROD_W = PRE_W + DIV_W + 1;
  localparam int CNT_W  = PROD_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_END, ST_GAP} state_t;
  state_t state;

  logic [CNT_W-1:0]  cnt, halfEnd, gapEnd;
  logic [PROD_W-1:0] prod, half;
  logic [EDGE_W-1:0] edgeCnt, lastEdge;
  logic [LEN_W-1:0]  wordLen;
  logic sckInt, tick, canStart, keepFrame;

  assign prod     = PROD_W'(cfg.prescale) * (PROD_W'(cfg.rateDiv) + 1'b1);
  assign half     = ((prod >> 1) == '0) ? PROD_W'(1) : (prod >> 1);
  assign halfEnd  = CNT_W'(half) - 1'b1;
  assign gapEnd   = (CNT_W'(half) << 1) - 1'b1;
  assign wordLen  = LEN_W'(cfg.sizeM1) + 1'b1;
  assign lastEdge = {wordLen, 1'b0} - 1'b1;
  assign canStart = cfg.enable && !cfg.txHold && !txEmpty;
  assign keepFrame = cfg.blockMode && !curStop && canStart;
  assign tick     = ((state == ST_SHIFT) || (state == ST_END)) && (cnt == halfEnd);

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE:  strobes.load = canStart;
      ST_SHIFT: if (tick) begin
        if (!sckInt) begin
          strobes.outEdge    = cfg.cpha;
          strobes.sampleEdge = !cfg.cpha;
        end else begin
          strobes.sampleEdge = cfg.cpha;
          strobes.outEdge    = !cfg.cpha && (edgeCnt != lastEdge);
        end
      end
      ST_END: begin
        strobes.rxPush = (cnt == '0);
        strobes.load   = tick && keepFrame;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      edgeCnt     <= '0;
      sckInt      <= 1'b0;
      frameActive <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (canStart) begin
          state       <= ST_SHIFT;
          frameActive <= 1'b1;
          cnt         <= '0;
          edgeCnt     <= '0;
        end
        ST_SHIFT: begin
          if (tick) begin
            cnt     <= '0;
            sckInt  <= !sckInt;
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == lastEdge) state <= ST_END;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_END: begin
          if (tick) begin
            cnt     <= '0;
            edgeCnt <= '0;
            if (keepFrame) begin
              state <= ST_SHIFT;
            end else begin
              state       <= ST_GAP;
              frameActive <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == gapEnd) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sck = cfg.cpol ^ sckInt;
  assign csN = (frameActive && !cfg.csOff) ? ~(NUM_CS'(1) << cfg.csSel) : '1;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [7:0]  csN
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  spiCfg_t     cfg;
  spiStrobes_t strobes;
  logic txEmpty, txFull, curStop, frameActive;
  logic [CW-1:0] txCount, rxCount;
  logic dataWrite, txFlush;

  assign dataWrite = regWe && (regAddr == ADDR_DATA);
  assign txFlush   = regWe && (regAddr == ADDR_FLUSH) && regWdata[1];

  spi_fifo_dp #(.DEPTH(FIFO_DEPTH)) dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .miso(miso), .strobes(strobes),
    .cfg(cfg), .txEmpty(txEmpty), .txFull(txFull), .curStop(curStop),
    .mosi(mosi), .txCount(txCount), .rxCount(rxCount));

  spi_fifo_ctrl ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .txEmpty(txEmpty), .curStop(curStop),
    .strobes(strobes), .sck(sck), .csN(csN), .frameActive(frameActive));
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [7:0]    csN,
  input logic          sck,
  input logic          cpol,
  input logic          csOff,
  input logic          txHold,
  input logic          enable,
  input logic          frameActive,
  input logic          txFull,
  input logic          dataWrite,
  input logic          txPop,
  input logic          txFlush,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount
);
  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_cs_muted_R7: assert property (@(posedge clk) disable iff (!rstN)
    csOff |-> (csN == 8'hFF));

  assert_sck_rest_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!frameActive && !csOff && (csN == 8'hFF)) |-> (sck == cpol));

  assert_hold_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txHold && !frameActive) |=> !frameActive);

  assert_enable_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !frameActive) |=> !frameActive);

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && dataWrite && !txPop && !txFlush) |=> (txCount == CW'(DEPTH)));

  assert_rx_bound_R13: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CW'(DEPTH));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(FIFO_DEPTH)) chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .cpol(cfg.cpol),
  .csOff(cfg.csOff), .txHold(cfg.txHold), .enable(cfg.enable),
  .frameActive(frameActive), .txFull(txFull), .dataWrite(dataWrite),
  .txPop(strobes.load), .txFlush(txFlush), .txCount(txCount), .rxCount(rxCount));

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic sck, mosi;
  logic miso = 1'b0;
  logic [7:0] csN;

  int checks = 0, fails = 0;
  bit finished = 0;

  spi_fifo_master uut (.clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .sck(sck),
    .mosi(mosi), .miso(miso), .csN(csN));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // bench-side slave and pin monitors
  int benchSel = 0;
  logic selCs, anyLow;
  assign selCs  = csN[benchSel];
  assign anyLow = ~&csN;
  logic [15:0] slvTx = '0, slvRx = '0;
  int slvLen = 8, slvIdx = 0, slvEdges = 0, selFalls = 0, anyFalls = 0;
  bit slvCpol = 0, slvCpha = 0;
  time lastRise = 0, risePeriod = 0, csRiseT = 0, gapT = 0;

  always @(negedge selCs) begin
    selFalls++;
    slvRx = '0;
    slvEdges = 0;
    if (csRiseT > 0) gapT = $time - csRiseT;
    if (!slvCpha) begin
      miso = slvTx[slvLen-1];
      slvIdx = slvLen - 2;
    end else begin
      slvIdx = slvLen - 1;
    end
  end
  always @(posedge selCs) csRiseT = $time;
  always @(posedge anyLow) anyFalls++;
  always @(posedge sck) begin
    risePeriod = $time - lastRise;
    lastRise = $time;
  end
  always @(sck) begin
    if (selCs === 1'b0) begin
      slvEdges++;
      if ((sck != slvCpol) == !slvCpha) slvRx = {slvRx[14:0], mosi};
      else if (slvIdx >= 0) begin
        miso = slvTx[slvIdx];
        slvIdx--;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRe = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      regRead(3'd3, s);
      if (s[2]) break;
    end
    repeat (200) @(posedge clk);
  endtask

  task automatic setFmt(input int len, input bit cpol, input bit cpha, input int div);
    slvLen = len; slvCpol = cpol; slvCpha = cpha;
    regWrite(3'd0, 32'((div << 8) | (int'(cpha) << 5) | (int'(cpol) << 4) | (len - 1)));
  endtask

  task automatic testReset();
    logic [31:0] s;
    check("R1 csN idle", 32'(csN), 32'hFF);
    check("R1 sck idle", 32'(sck), 32'h0);
    regRead(3'd3, s);
    check("R1 status after reset", s, 32'h5);
    regRead(3'd0, s);
    check("R1 reset length field", s & 32'hF, 32'h7);
  endtask

  task automatic testLoopback();
    logic [31:0] d;
    benchSel = 0;
    miso = 1'b0;
    regWrite(3'd1, 32'h03);
    setFmt(16, 0, 0, 0);
    regWrite(3'd2, 32'h0000BEEF);
    waitDone();
    regRead(3'd2, d);
    check("R6 loopback 16-bit word", d, 32'hBEEF);
    setFmt(8, 0, 0, 0);
    regWrite(3'd2, 32'h000000A5);
    waitDone();
    regRead(3'd2, d);
    check("R5 one received word per sent word", d, 32'hA5);
    regRead(3'd3, d);
    check("R5 receive queue drained", d & 32'h2, 32'h0);
  endtask

  task automatic testModes();
    logic [31:0] d;
    benchSel = 2;
    regWrite(3'd1, 32'h41);
    for (int m = 0; m < 4; m++) begin
      slvTx = 16'(8'hC5 ^ m);
      setFmt(8, m[1], m[0], 0);
      regWrite(3'd2, 32'h3C);
      waitDone();
      check($sformatf("R3 mode %0d slave saw", m), 32'(slvRx[7:0]), 32'h3C);
      regRead(3'd2, d);
      check($sformatf("R3 mode %0d master got", m), d, 32'(8'hC5 ^ m));
      check($sformatf("R2 mode %0d edge count", m), 32'(slvEdges), 32'd16);
      check($sformatf("R1 mode %0d sck rest", m), 32'(sck), 32'(m[1]));
    end
    slvTx = 16'h000A;
    setFmt(4, 0, 0, 0);
    regWrite(3'd2, 32'hF9);
    waitDone();
    check("R2 4-bit slave saw", 32'(slvRx[3:0]), 32'h9);
    check("R2 4-bit edge count", 32'(slvEdges), 32'd8);
    regRead(3'd2, d);
    check("R2 4-bit masked receive", d, 32'hA);
    check("R7 selected line used", 32'(selFalls > 0), 32'd1);
  endtask

  task automatic testRate();
    logic [31:0] d;
    benchSel = 0;
    regWrite(3'd1, 32'h03);
    regWrite(3'd5, 32'd4);
    setFmt(8, 0, 0, 1);
    regWrite(3'd2, 32'h5A);
    waitDone();
    check("R4 sck period in clocks", 32'(risePeriod / CLK_PERIOD), 32'd8);
    regRead(3'd2, d);
    check("R4 word at slow rate", d, 32'h5A);
  endtask

  task automatic testGap();
    int f0;
    regWrite(3'd1, 32'h13);
    regWrite(3'd2, 32'h11);
    regWrite(3'd2, 32'h22);
    f0 = selFalls;
    regWrite(3'd1, 32'h03);
    waitDone();
    check("R9 one frame per word", 32'(selFalls - f0), 32'd2);
    check("R9 deselect time at least one period", 32'(gapT >= 8 * CLK_PERIOD), 32'd1);
    regWrite(3'd4, 32'h1);
    regWrite(3'd5, 32'd2);
    setFmt(8, 0, 0, 0);
  endtask

  task automatic testBlock();
    logic [31:0] d;
    int f0;
    benchSel = 0;
    regWrite(3'd1, 32'h1B);
    regWrite(3'd2, 32'h11);
    regWrite(3'd2, 32'h80000022);
    regWrite(3'd2, 32'h33);
    f0 = selFalls;
    repeat (100) @(posedge clk);
    check("R10 hold keeps selects high", 32'(csN), 32'hFF);
    check("R10 hold starts no frame", 32'(selFalls - f0), 32'd0);
    regRead(3'd3, d);
    check("R10 data still queued", d & 32'h4, 32'h0);
    regWrite(3'd1, 32'h0B);
    waitDone();
    check("R8 tagged word closes frame, empty closes next", 32'(selFalls - f0), 32'd2);
    for (int i = 1; i <= 3; i++) begin
      regRead(3'd2, d);
      check("R8 framed data order", d, 32'(8'h11 * i));
    end
  endtask

  task automatic testMuteEnable();
    logic [31:0] d;
    int a0;
    a0 = anyFalls;
    regWrite(3'd1, 32'h07);
    regWrite(3'd2, 32'h6B);
    waitDone();
    check("R7 mute keeps all selects high", 32'(anyFalls - a0), 32'd0);
    regRead(3'd2, d);
    check("R7 mute still shifts", d, 32'h6B);
    regWrite(3'd1, 32'h02);
    regWrite(3'd2, 32'h4D);
    repeat (100) @(posedge clk);
    check("R11 no frame while stopped", 32'(anyFalls - a0), 32'd0);
    regRead(3'd3, d);
    check("R11 word stays queued", d & 32'h4, 32'h0);
    regWrite(3'd1, 32'h03);
    waitDone();
    regRead(3'd2, d);
    check("R11 run releases word", d, 32'h4D);
  endtask

  task automatic testFull();
    logic [31:0] d;
    regWrite(3'd1, 32'h13);
    for (int i = 0; i < 17; i++) regWrite(3'd2, 32'(i + 1));
    regRead(3'd3, d);
    check("R12 not-full flag clear at 16", d & 32'h1, 32'h0);
    regWrite(3'd1, 32'h03);
    waitDone();
    regWrite(3'd2, 32'h77);
    waitDone();
    for (int i = 0; i < 16; i++) begin
      regRead(3'd2, d);
      check("R13 receive order with overflow discard", d, 32'(i + 1));
    end
    regRead(3'd2, d);
    check("R12 R13 extra words dropped, empty read zero", d, 32'h0);
    regRead(3'd3, d);
    check("R13 empty read changes nothing", d & 32'h2, 32'h0);
  endtask

  task automatic testFlush();
    logic [31:0] d;
    regWrite(3'd2, 32'h12);
    waitDone();
    regWrite(3'd1, 32'h13);
    regWrite(3'd2, 32'h34);
    regWrite(3'd2, 32'h56);
    regWrite(3'd4, 32'h2);
    regRead(3'd3, d);
    check("R14 transmit flush empties queue, receive kept", d & 32'h6, 32'h6);
    regWrite(3'd4, 32'h1);
    regRead(3'd3, d);
    check("R14 receive flush", d & 32'h2, 32'h0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 testReset();
    @(negedge clk) rstN = 1'b1;
    testReset();
    testLoopback();
    testModes();
    testRate();
    testGap();
    testBlock();
    testMuteEnable();
    testFull();
    testFlush();
    finish();
  end
endmodule